// File: doc/BRIEF.md
# Cascaded Shift-Register Serial Link

This block moves an 8-bit word from a parallel source to a parallel sink over one serial wire. Both ends are built by chaining small 4-bit universal shift registers, and both ends run from the same clock. Each 4-bit register supports four modes: hold, shift toward bit 0, shift toward the top bit, and parallel load. The transmit side loads the word in parallel. It then shifts the word out one bit per clock, least significant bit first. The receive side shifts the same stream in and ends up holding the complete word on its parallel outputs.

A small sequencer sets the mode of both chains. A start pulse in an idle cycle loads the transmit chain on that clock edge. The next eight clocks shift both chains together. After the eighth shift, a single-cycle valid pulse marks the received word as ready. Inside each chain, the serial output of one 4-bit stage feeds the serial input of its neighbour, so two stages act as one 8-bit register.

Top module: `serial_link_top`

## Requirements
- R1: After reset, busy, rx_valid and line are 0 and rx_word is 0.
- R2: A start seen high at a clock edge while busy is low captures tx_word on that edge. busy is then high for exactly 8 cycles.
- R3: In the k-th cycle after the capturing edge (k = 0..7), line carries bit k of the captured word. Bit 0 is sent first.
- R4: rx_valid is high for exactly one cycle: the cycle right after the last of the 8 busy cycles.
- R5: While rx_valid is high, rx_word equals the captured word. It holds that value until the next transfer's first shift.
- R6: start is ignored while busy is high. Neither the line sequence nor the received word changes, and no extra transfer follows.
- R7: A start raised in the rx_valid cycle begins a new transfer at once. rx_word keeps the previous word until the first shift of the new transfer.
- R8: line is 0 whenever busy is low.
- R9: The cascade is seamless: bits that cross the boundary between the two 4-bit stages arrive in order on both sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ends |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send tx_word |
| tx_word | input | 8 | Parallel word to send |
| line | output | 1 | Serial wire between the two chains |
| rx_word | output | 8 | Reassembled parallel word |
| rx_valid | output | 1 | One-cycle pulse: rx_word is new |
| busy | output | 1 | Transfer in progress |

## Verification
The words are chosen so that different faults give different results:
- Alternating patterns (0x55, 0xAA) and single-bit words (0x01, 0x80) expose reversed bit order and off-by-one shift counts.
- Words whose two nibbles differ (0x0F, 0xF0, 0x3C) show whether data crosses the stage boundary in the right direction.
- All-zero and all-one words show that the fill bit never leaks into the data.

Random words are also sent, each compared with the word that was sent. Directed cases cover the following:
- a start raised in the middle of a transfer, which must be ignored;
- a start raised in the valid cycle, which must begin a new transfer at once;
- the idle level of the line.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic [1:0] {
    M_HOLD  = 2'b00,
    M_RIGHT = 2'b01,
    M_LEFT  = 2'b10,
    M_LOAD  = 2'b11
  } shmode_t;
endpackage

// File: rtl/uni_shift.sv
module uni_shift #(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  link_pkg::shmode_t mode,
  input  logic [W-1:0]     par_in,
  input  logic             sin_lo,
  input  logic             sin_hi,
  output logic [W-1:0]     q
);
  function automatic logic [W-1:0] next_q(
    input link_pkg::shmode_t m,
    input logic [W-1:0] cur,
    input logic [W-1:0] par,
    input logic lo,
    input logic hi
  );
    case (m)
      link_pkg::M_RIGHT: next_q = {hi, cur[W-1:1]};
      link_pkg::M_LEFT:  next_q = {cur[W-2:0], lo};
      link_pkg::M_LOAD:  next_q = par;
      default:           next_q = cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= next_q(mode, q, par_in, sin_lo, sin_hi);
  end
endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int STAGE_W  = 4,
  parameter int N_STAGES = 2,
  localparam int WORD_W  = STAGE_W * N_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  link_pkg::shmode_t mode,
  input  logic [WORD_W-1:0] par_in,
  input  logic              ser_in,
  output logic [WORD_W-1:0] q
);
  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    logic hi_in;
    logic lo_in;
    if (s == N_STAGES - 1) begin : g_top
      assign hi_in = ser_in;
    end else begin : g_mid
      assign hi_in = q[(s+1)*STAGE_W];
    end
    if (s == 0) begin : g_bot
      assign lo_in = 1'b0;
    end else begin : g_up
      assign lo_in = q[s*STAGE_W-1];
    end
    uni_shift #(.W(STAGE_W)) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode),
      .par_in (par_in[s*STAGE_W +: STAGE_W]),
      .sin_lo (lo_in),
      .sin_hi (hi_in),
      .q      (q[s*STAGE_W +: STAGE_W])
    );
  end
endmodule

// File: rtl/link_seq.sv
module link_seq #(
  parameter int WORD_W = 8,
  localparam int CW    = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output link_pkg::shmode_t tx_mode,
  output link_pkg::shmode_t rx_mode,
  output logic              busy,
  output logic              done
);
  logic          shifting;
  logic [CW-1:0] cnt;
  logic          accept;
  logic          last;

  assign accept = start && !shifting;
  assign last   = shifting && (cnt == CW'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shifting <= 1'b0;
      cnt      <= '0;
      done     <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        shifting <= 1'b1;
        cnt      <= '0;
      end else if (last) begin
        shifting <= 1'b0;
      end else if (shifting) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (accept)        tx_mode = link_pkg::M_LOAD;
    else if (shifting) tx_mode = link_pkg::M_RIGHT;
    else               tx_mode = link_pkg::M_HOLD;
    rx_mode = shifting ? link_pkg::M_RIGHT : link_pkg::M_HOLD;
  end

  assign busy = shifting;
endmodule

// File: rtl/serial_link_top.sv
module serial_link_top #(
  parameter int STAGE_W  = 4,
  parameter int N_STAGES = 2,
  localparam int WORD_W  = STAGE_W * N_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  output logic              line,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              busy
);
  link_pkg::shmode_t tx_mode;
  link_pkg::shmode_t rx_mode;
  logic [WORD_W-1:0] tx_q;

  link_seq #(.WORD_W(WORD_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tx_mode (tx_mode),
    .rx_mode (rx_mode),
    .busy    (busy),
    .done    (rx_valid)
  );

  shift_chain #(.STAGE_W(STAGE_W), .N_STAGES(N_STAGES)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (tx_mode),
    .par_in (tx_word),
    .ser_in (1'b0),
    .q      (tx_q)
  );

  assign line = tx_q[0];

  shift_chain #(.STAGE_W(STAGE_W), .N_STAGES(N_STAGES)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (rx_mode),
    .par_in ('0),
    .ser_in (line),
    .q      (rx_word)
  );
endmodule

// File: rtl/link_checker.sv
module link_checker #(
  parameter int WORD_W = 8,
  localparam int RW    = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              line,
  input logic              rx_valid,
  input logic [WORD_W-1:0] rx_word
);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < RW'(WORD_W)));
  p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(run) == RW'(WORD_W - 1)));
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_valid_place_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(busy) && !busy));
  p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(rx_word));
  p_idle_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line);
endmodule

bind serial_link_top link_checker #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .line     (line),
  .rx_valid (rx_valid),
  .rx_word  (rx_word)
);

// File: tb/serial_link_top_tb.sv
module serial_link_top_tb;
  localparam int CLK_P = 10;
  localparam int NV    = 10;
  localparam logic [7:0] VEC [NV] = '{8'h55, 8'hAA, 8'h01, 8'h80, 8'h0F,
                                      8'hF0, 8'h3C, 8'h00, 8'hFF, 8'hB6};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] tx_word = '0;
  logic       line;
  logic [7:0] rx_word;
  logic       rx_valid;
  logic       busy;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_link_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
    .line(line), .rx_word(rx_word), .rx_valid(rx_valid), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge. Sends w; if inject, raises start with ~w mid-run.
  // Returns at the negedge after the last shift (the valid cycle).
  task automatic xfer(input logic [7:0] w, input bit inject);
    start   = 1'b1;
    tx_word = w;
    @(negedge clk);
    start   = 1'b0;
    tx_word = ~w;
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk);
      start = inject && (k == 3);
      chk(busy == 1'b1, "R2 busy during shift", {7'b0, busy}, 8'h01);
      chk(line == w[k], "R3 R9 serial bit order", {7'b0, line}, {7'b0, w[k]});
    end
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R2 busy length", {7'b0, busy}, 8'h00);
    chk(rx_valid == 1'b1, "R4 valid pulse", {7'b0, rx_valid}, 8'h01);
    chk(rx_word == w, "R5 R9 received word", rx_word, w);
    chk(line == 1'b0, "R8 idle line", {7'b0, line}, 8'h00);
  endtask

  task automatic after_valid(input logic [7:0] w);
    @(negedge clk);
    chk(rx_valid == 1'b0, "R4 valid single cycle", {7'b0, rx_valid}, 8'h00);
    chk(rx_word == w, "R5 word holds", rx_word, w);
    chk(busy == 1'b0, "R6 no extra transfer", {7'b0, busy}, 8'h00);
    chk(line == 1'b0, "R8 idle line", {7'b0, line}, 8'h00);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0 && rx_valid == 1'b0 && line == 1'b0, "R1 reset flags",
        {5'b0, busy, rx_valid, line}, 8'h00);
    chk(rx_word == 8'h00, "R1 reset word", rx_word, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i], 1'b0);
      after_valid(VEC[i]);
    end

    for (int i = 0; i < 6; i++) begin
      logic [7:0] w;
      w = 8'($urandom);
      xfer(w, 1'b0);
      after_valid(w);
    end

    // R6: start mid-transfer is ignored
    xfer(8'hC3, 1'b1);
    after_valid(8'hC3);
    after_valid(8'hC3);

    // R7: start in the valid cycle begins a new transfer at once
    xfer(8'h96, 1'b0);
    start   = 1'b1;
    tx_word = 8'h4E;
    @(negedge clk);
    start   = 1'b0;
    chk(busy == 1'b1, "R7 back-to-back accepted", {7'b0, busy}, 8'h01);
    chk(rx_word == 8'h96, "R7 old word kept", rx_word, 8'h96);
    chk(line == 1'b0, "R7 first bit", {7'b0, line}, 8'h00);
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      chk(line == tx_word[k], "R7 serial bit", {7'b0, line}, {7'b0, tx_word[k]});
    end
    @(negedge clk);
    chk(rx_valid == 1'b1 && rx_word == 8'h4E, "R7 second word", rx_word, 8'h4E);
    after_valid(8'h4E);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule